// File: doc/BRIEF.md
# CGMS/WSS Line Data Serializer

This block puts copy-control or aspect-ratio signalling into one video line as a serial stream of logic-level elements. In NTSC mode it sends a 20-bit copy-generation word behind a single reference element. Odd and even fields each have their own enable. The six check bits of that word are either worked out by the block or taken unchanged from the supplied word. In PAL mode it sends a 14-bit wide-screen word on line 23. That word follows a fixed run-in and start code, and each data bit becomes a six-element biphase group.

The surrounding video timing gives a one-cycle `line_start` strobe together with the current line number and field flag. When the line qualifies, the block takes a copy of the word and control inputs. After a fixed lead-in it drives `bit_out` with `bit_valid` high for the whole burst. A later stage turns these elements into video amplitude.

Top module: `cgms_wss_serializer`

## Requirements
- R1: In NTSC mode (`std_pal`=0) a burst is 21 elements of `CGMS_BIT_CYC` cycles each: one reference element followed by the 20 word bits, bit 0 first and bit 19 last.
- R2: A burst starts only on a qualifying line: NTSC odd field (`field_even`=0) on line 20, NTSC even field (`field_even`=1) on line 283, PAL on line 23 of either field. A `line_start` on any other line produces no output.
- R3: The reference element that opens an NTSC burst is 1 and lasts exactly one data-bit time.
- R4: `en_odd` gates NTSC bursts on odd fields and `en_even` gates them on even fields, each without effect on the other.
- R5: With `crc_auto`=1, bits 19:14 of the sent word are c[5:0], with c[0] at bit 14. c starts at 6'h3F. For each `cgms_word` bit d, from bit 0 to bit 13: f = d ^ c[5], then c = {c[4:0],0} ^ {0000,f,f}. This is polynomial x^6+x+1.
- R6: With `crc_auto`=0, all 20 bits of `cgms_word` are sent as given.
- R7: In PAL mode a burst is 137 elements of `WSS_ELEM_CYC` cycles each. First comes the run-in 1111100011100011100011100 0111, then the start code 000111100011110000011111, both leftmost element first. Last come the 14 `wss_word` bits, bit 0 first, each sent as 000111 for a 0 or 111000 for a 1.
- R8: Word, mode and control inputs are sampled only with the accepted `line_start`. Changes while a burst is pending or running do not alter it.
- R9: No burst starts in PAL mode when `wss_en`=0. CGMS data is never sent in PAL mode, and WSS data is never sent in NTSC mode.
- R10: `bit_valid` first rises `START_DLY` cycles after the clock edge that accepts `line_start`. A `line_start` that arrives while a burst is pending or running is ignored.
- R11: After reset, and whenever `bit_valid` is low, `bit_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| std_pal | input | 1 | 0 = NTSC (CGMS), 1 = PAL (WSS) |
| line_start | input | 1 | One-cycle strobe at the start of each line |
| line_num | input | LINE_W | Current line number, valid with `line_start` |
| field_even | input | 1 | 0 = odd field, 1 = even field |
| cgms_word | input | 20 | CGMS payload in 13:0, check bits in 19:14 |
| crc_auto | input | 1 | 1 = replace bits 19:14 with the computed check |
| en_odd | input | 1 | Enable CGMS on odd fields |
| en_even | input | 1 | Enable CGMS on even fields |
| wss_word | input | 14 | WSS data bits |
| wss_en | input | 1 | Enable WSS on line 23 |
| bit_out | output | 1 | Current serial element |
| bit_valid | output | 1 | High while a burst element is on `bit_out` |

## Verification
The assertions assume that `line_start` is sampled together with a stable line number, field flag and standard. From that sample the checked properties read back the line, field and enable that were in force. The stimulus holds these inputs steady around every strobe. Words and controls are changed only mid-burst, to probe R8, and a second strobe is given only inside a running burst, to probe R10. Random lines are picked half from the qualifying set and half from the whole frame. The random stream is seeded once, so every run sees the same sequence.

// File: rtl/cgms_wss_serializer.sv
module cgms_wss_serializer #(
  parameter int LINE_W         = 10,
  parameter int CGMS_BIT_CYC   = 8,
  parameter int WSS_ELEM_CYC   = 2,
  parameter int START_DLY      = 12,
  parameter int CGMS_LINE_ODD  = 20,
  parameter int CGMS_LINE_EVEN = 283,
  parameter int WSS_LINE       = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              std_pal,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_even,
  input  logic [19:0]       cgms_word,
  input  logic              crc_auto,
  input  logic              en_odd,
  input  logic              en_even,
  input  logic [13:0]       wss_word,
  input  logic              wss_en,
  output logic              bit_out,
  output logic              bit_valid
);
  localparam int RUN_N      = 29;
  localparam int START_N    = 24;
  localparam int HDR_N      = RUN_N + START_N;
  localparam int WSS_ELEMS  = HDR_N + 14 * 6;
  localparam int CGMS_ELEMS = 21;
  localparam int IDX_W      = $clog2(WSS_ELEMS);
  localparam int MAXC       = (CGMS_BIT_CYC > WSS_ELEM_CYC) ? CGMS_BIT_CYC : WSS_ELEM_CYC;
  localparam int SUB_W      = $clog2(MAXC + 1);
  localparam int LEAD_W     = $clog2(START_DLY + 1);
  localparam logic [RUN_N-1:0]   RUNIN = 29'b11111_000111_000111_000111_000111;
  localparam logic [START_N-1:0] SCODE = 24'b000_1111_000_1111_00000_11111;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SEND} st_t;

  st_t               state;
  logic              pal_q;
  logic [19:0]       cg_q;
  logic [13:0]       ws_q;
  logic [LEAD_W-1:0] lead_cnt;
  logic [SUB_W-1:0]  sub_cnt;
  logic [IDX_W-1:0]  idx;

  function automatic logic [5:0] crc6(input logic [13:0] d);
    logic [5:0] c;
    logic       f;
    c = 6'h3F;
    for (int i = 0; i < 14; i++) begin
      f = d[i] ^ c[5];
      c = {c[4:0], 1'b0} ^ {4'b0000, f, f};
    end
    return c;
  endfunction

  wire hit_ntsc = (!field_even && en_odd  && line_num == LINE_W'(CGMS_LINE_ODD)) ||
                  ( field_even && en_even && line_num == LINE_W'(CGMS_LINE_EVEN));
  wire hit_pal  = wss_en && line_num == LINE_W'(WSS_LINE);
  wire go       = line_start && state == S_IDLE && (std_pal ? hit_pal : hit_ntsc);

  wire [SUB_W-1:0] elem_last = pal_q ? SUB_W'(WSS_ELEM_CYC - 1) : SUB_W'(CGMS_BIT_CYC - 1);
  wire [IDX_W-1:0] idx_last  = pal_q ? IDX_W'(WSS_ELEMS - 1) : IDX_W'(CGMS_ELEMS - 1);
  wire             elem_end  = sub_cnt == elem_last;

  wire [IDX_W-1:0] rel   = idx - IDX_W'(HDR_N);
  wire [IDX_W-1:0] dbit  = rel / IDX_W'(6);
  wire [IDX_W-1:0] dpos  = rel - dbit * IDX_W'(6);
  wire             dval  = ws_q[dbit[3:0]];
  wire             w_el  = (idx < IDX_W'(RUN_N)) ? RUNIN[IDX_W'(RUN_N - 1) - idx] :
                           (idx < IDX_W'(HDR_N)) ? SCODE[IDX_W'(HDR_N - 1) - idx] :
                           (dval ? (dpos < IDX_W'(3)) : (dpos >= IDX_W'(3)));
  wire             c_el  = (idx == '0) ? 1'b1 : cg_q[5'(idx - IDX_W'(1))];

  assign bit_valid = state == S_SEND;
  assign bit_out   = bit_valid && (pal_q ? w_el : c_el);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pal_q    <= 1'b0;
      cg_q     <= '0;
      ws_q     <= '0;
      lead_cnt <= '0;
      sub_cnt  <= '0;
      idx      <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state    <= S_LEAD;
          pal_q    <= std_pal;
          cg_q     <= crc_auto ? {crc6(cgms_word[13:0]), cgms_word[13:0]} : cgms_word;
          ws_q     <= wss_word;
          lead_cnt <= '0;
        end
        S_LEAD: begin
          lead_cnt <= lead_cnt + 1'b1;
          if (lead_cnt == LEAD_W'(START_DLY - 1)) begin
            state   <= S_SEND;
            sub_cnt <= '0;
            idx     <= '0;
          end
        end
        S_SEND: begin
          if (elem_end) begin
            sub_cnt <= '0;
            if (idx == idx_last) state <= S_IDLE;
            else                 idx   <= idx + 1'b1;
          end else begin
            sub_cnt <= sub_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LEAD && $past(state) == S_IDLE) |->
      ($past(std_pal) ? $past(line_num) == LINE_W'(WSS_LINE)
                      : ($past(line_num) == LINE_W'(CGMS_LINE_ODD) ||
                         $past(line_num) == LINE_W'(CGMS_LINE_EVEN))));

  p_field_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LEAD && $past(state) == S_IDLE && !$past(std_pal)) |->
      ($past(field_even) ? $past(en_even) : $past(en_odd)));

  p_wss_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LEAD && $past(state) == S_IDLE && $past(std_pal)) |-> $past(wss_en));

  p_ref_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bit_valid) && !pal_q) |-> bit_out);

  p_runin_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bit_valid) && pal_q) |-> bit_out);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> ($stable(cg_q) && $stable(ws_q) && $stable(pal_q)));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> !bit_out);
endmodule

// File: tb/cgms_wss_serializer_bench.sv
module cgms_wss_serializer_bench;
  localparam int CBC = 8;
  localparam int WEC = 2;
  localparam int DLY = 12;
  localparam int WIN = DLY + 137 * WEC + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic std_pal = 1'b0, line_start = 1'b0, field_even = 1'b0;
  logic [9:0]  line_num = '0;
  logic [19:0] cgms_word = '0;
  logic [13:0] wss_word = '0;
  logic crc_auto = 1'b0, en_odd = 1'b0, en_even = 1'b0, wss_en = 1'b0;
  logic bit_out, bit_valid;

  int tests = 0;
  int fails = 0;
  bit exp_el [0:199];
  int n_el;
  int el_len;

  always #2.5 clk = ~clk;

  cgms_wss_serializer #(.LINE_W(10), .CGMS_BIT_CYC(CBC), .WSS_ELEM_CYC(WEC), .START_DLY(DLY))
  u_cgms_wss_serializer (
    .clk(clk), .rst_n(rst_n), .std_pal(std_pal), .line_start(line_start), .line_num(line_num),
    .field_even(field_even), .cgms_word(cgms_word), .crc_auto(crc_auto), .en_odd(en_odd),
    .en_even(en_even), .wss_word(wss_word), .wss_en(wss_en), .bit_out(bit_out), .bit_valid(bit_valid));

  function automatic logic [5:0] ref_crc(input logic [13:0] d);
    logic [5:0] c = 6'h3F;
    logic f;
    for (int i = 0; i < 14; i++) begin
      f = d[i] ^ c[5];
      c = {c[4:0], 1'b0} ^ {4'b0000, f, f};
    end
    return c;
  endfunction

  function automatic bit qualifies();
    if (std_pal) return wss_en && line_num == 10'd23;
    if (!field_even) return en_odd && line_num == 10'd20;
    return en_even && line_num == 10'd283;
  endfunction

  task automatic build_exp();
    logic [28:0] run = 29'b11111_000111_000111_000111_000111;
    logic [23:0] sc  = 24'b000_1111_000_1111_00000_11111;
    logic [19:0] w;
    n_el = 0;
    if (!qualifies()) return;
    if (!std_pal) begin
      w = crc_auto ? {ref_crc(cgms_word[13:0]), cgms_word[13:0]} : cgms_word;
      exp_el[0] = 1'b1;
      for (int k = 0; k < 20; k++) exp_el[k + 1] = w[k];
      n_el = 21; el_len = CBC;
    end else begin
      for (int i = 0; i < 29; i++) exp_el[i] = run[28 - i];
      for (int i = 0; i < 24; i++) exp_el[29 + i] = sc[23 - i];
      for (int b = 0; b < 14; b++)
        for (int p = 0; p < 6; p++)
          exp_el[53 + b * 6 + p] = wss_word[b] ? (p < 3) : (p >= 3);
      n_el = 137; el_len = WEC;
    end
  endtask

  task automatic run_line(input bit scramble, input bit repulse, input string tag);
    bit ok = 1'b1;
    bit ev, eb;
    int bad_n = -1;
    logic av = 1'b0, ab = 1'b0;
    build_exp();
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int n = 0; n < WIN; n++) begin
      ev = (n >= DLY) && (n < DLY + n_el * el_len);
      eb = ev ? exp_el[(n - DLY) / el_len] : 1'b0;
      if (ok && (bit_valid !== ev || bit_out !== eb)) begin
        ok = 1'b0; bad_n = n; av = bit_valid; ab = bit_out;
      end
      if (repulse && n == 40) line_start = 1'b1;
      if (repulse && n == 41) line_start = 1'b0;
      if (scramble && n == 50) begin
        cgms_word = 20'($urandom); wss_word = 14'($urandom);
        crc_auto = ~crc_auto; std_pal = ~std_pal; field_even = ~field_even;
        en_odd = ~en_odd; en_even = ~en_even; wss_en = ~wss_en;
      end
      @(negedge clk);
    end
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at n=%0d: valid/bit actual %b/%b expected %b/%b", tag, bad_n, av, ab,
               (bad_n >= DLY) && (bad_n < DLY + n_el * el_len),
               ((bad_n >= DLY) && (bad_n < DLY + n_el * el_len)) ? exp_el[(bad_n - DLY) / el_len] : 1'b0);
    end
  endtask

  task automatic setup(input bit pal, input bit fe, input int ln, input bit eo, input bit ee,
                       input bit we, input bit ca, input logic [19:0] cw, input logic [13:0] ww);
    std_pal = pal; field_even = fe; line_num = 10'(ln); en_odd = eo; en_even = ee;
    wss_en = we; crc_auto = ca; cgms_word = cw; wss_word = ww;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    tests++;
    if (bit_valid !== 1'b0 || bit_out !== 1'b0) begin
      fails++;
      $display("FAIL R11 reset: valid/bit actual %b/%b expected 0/0", bit_valid, bit_out);
    end
    rst_n = 1'b1;
    @(negedge clk);

    setup(0, 0, 20, 1, 0, 0, 1, 20'h00000, 14'h0);     run_line(0, 0, "R1 R5 odd line 20 auto crc zero");
    setup(0, 1, 283, 0, 1, 0, 1, 20'h02A5B, 14'h0);    run_line(0, 0, "R2 R5 even line 283 auto crc");
    setup(0, 0, 20, 1, 1, 0, 0, 20'hA5C3F, 14'h0);     run_line(0, 0, "R3 R6 manual crc kept");
    setup(0, 0, 20, 0, 1, 0, 1, 20'hFFFFF, 14'h0);     run_line(0, 0, "R4 odd disabled");
    setup(0, 1, 283, 1, 0, 0, 1, 20'hFFFFF, 14'h0);    run_line(0, 0, "R4 even disabled");
    setup(0, 0, 283, 1, 1, 0, 1, 20'h12345, 14'h0);    run_line(0, 0, "R2 wrong field for line");
    setup(1, 0, 23, 0, 0, 1, 0, 20'h0, 14'h3FFF);      run_line(0, 0, "R7 wss all ones");
    setup(1, 1, 23, 0, 0, 1, 0, 20'h0, 14'h1555);      run_line(0, 0, "R7 wss alternating");
    setup(1, 0, 23, 1, 1, 0, 0, 20'h0, 14'h2AAA);      run_line(0, 0, "R9 wss disabled");
    setup(1, 0, 20, 1, 1, 1, 1, 20'h0, 14'h2AAA);      run_line(0, 0, "R9 PAL on cgms line");
    setup(0, 0, 23, 1, 1, 1, 1, 20'h0, 14'h2AAA);      run_line(0, 0, "R9 NTSC on wss line");
    setup(0, 0, 20, 1, 1, 0, 1, 20'h0F0F0, 14'h0);     run_line(1, 0, "R8 cgms mid-line write");
    setup(1, 0, 23, 0, 0, 1, 0, 20'h0, 14'h0C3A);      run_line(1, 0, "R8 wss mid-line write");
    setup(0, 1, 283, 1, 1, 0, 0, 20'h9D2E1, 14'h0);    run_line(0, 1, "R10 strobe while busy cgms");
    setup(1, 1, 23, 0, 0, 1, 0, 20'h0, 14'h1234);      run_line(0, 1, "R10 strobe while busy wss");

    for (int t = 0; t < 40; t++) begin
      std_pal = 1'($urandom); field_even = 1'($urandom);
      en_odd = ($urandom % 4) != 0; en_even = ($urandom % 4) != 0; wss_en = ($urandom % 4) != 0;
      crc_auto = 1'($urandom);
      cgms_word = 20'($urandom); wss_word = 14'($urandom);
      if ($urandom % 2) line_num = std_pal ? 10'd23 : (field_even ? 10'd283 : 10'd20);
      else line_num = 10'($urandom % 625);
      run_line(1'($urandom % 4 == 0), 1'($urandom % 4 == 0), "R1 R2 R7 random line");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule